// File: doc/BRIEF.md
# Clocked Serial Port with Clear-to-Send

This block is the device end of a four-wire synchronous serial link. The external partner drives the serial clock. The block receives frames on a data-in line and sends frames on a data-out line. It drives a clear-to-send output that tells the partner when it may send the next frame. Toward the core it offers one byte-wide transmit channel and one byte-wide receive channel. Each channel uses a valid/ready handshake and holds a single byte.

Each frame has ten bits: a start bit of 0, eight data bits sent least significant bit first, and a routing bit that closes the frame. The port sends the routing bit as 0 and expects 0 when it receives one. All logic runs on the serial clock. Data-in is sampled on the rising edge. Data-out is updated on the falling edge, so it is stable when the partner samples it on the rising edge.

The receiver state machine has four states: RX_IDLE, RX_DATA, RX_ROUTE and RX_HOLD. It moves from RX_IDLE to RX_DATA on a 0 start bit, from RX_DATA to RX_ROUTE after the last data bit, and from RX_ROUTE to RX_HOLD after the routing bit. It moves from RX_HOLD back to RX_IDLE on the receive handshake.

The transmitter state machine also has four states: TX_IDLE, TX_START, TX_DATA and TX_ROUTE. It moves from TX_IDLE to TX_START when it accepts a byte, and from TX_START to TX_DATA on the next edge. It moves from TX_DATA to TX_ROUTE after the last data bit, and from TX_ROUTE back to TX_IDLE on the next edge.

Top module: `syncser_port`

## Requirements
- R1: An outgoing frame appears at the partner's rising-edge samples as ten bits in this order: 0, data bits 0 to 7 (least significant first), then 0. The first of these samples is taken one rising edge after the byte is accepted.
- R2: Data-out is high whenever no frame is being sent, including at the rising edge on which a byte is accepted and at the edge after the routing bit. It changes only on falling edges.
- R3: An incoming frame is shifted in least significant bit first. The byte appears on rx_data with rx_valid high right after the rising edge that samples the routing bit.
- R4: tx_ready is high only while the transmitter is idle and no receive is in progress. An accepted byte drops tx_ready until its frame ends.
- R5: While a frame is being received (clear-to-send low, no byte pending), tx_ready stays low and data-out stays high.
- R6: When data-in is 0 at a rising edge while clear-to-send is high, clear-to-send is low after that edge.
- R7: Clear-to-send stays low, and rx_data and rx_valid stay unchanged, until the rising edge where rx_valid and rx_ready are both high. While it is low, data-in is ignored. Clear-to-send is high after that edge.
- R8: If a start bit and a transmit request arrive at the same edge, the receive wins: tx_ready is low during that edge. The byte is accepted at the first edge after the routing bit has been sampled.
- R9: rx_err is high with the delivered byte when the received routing bit is 1, and low when it is 0. The data is delivered in both cases.
- R10: After reset, clear-to-send is high, data-out is high, rx_valid is low and tx_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock from the partner |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 1 | Serial data from the partner |
| sdo | output | 1 | Serial data to the partner, updated on falling edges |
| cts | output | 1 | Clear-to-send, high when a frame may be sent in |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte accepted at this edge if tx_valid |
| rx_data | output | DATA_W | Received byte |
| rx_valid | output | 1 | Received byte pending |
| rx_ready | input | 1 | Core takes the pending byte |
| rx_err | output | 1 | Routing bit of the pending byte was not 0 |

## Verification
The assertions assume the partner respects clear-to-send: it drives a start bit only while clear-to-send is high and keeps data-in high between frames. They also assume the core holds tx_valid until it is accepted. The stimulus drives data-in and the handshake inputs only on falling edges, keeps data-in high except inside a frame, and deliberately drives data-in low while a byte is held, to show that it is ignored. The same-edge case raises a start bit and a transmit request on the same falling edge.

// File: rtl/syncser_pkg.sv
package syncser_pkg;
    typedef enum logic [1:0] {
        RX_IDLE,
        RX_DATA,
        RX_ROUTE,
        RX_HOLD
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_ROUTE
    } tx_state_t;
endpackage

// File: rtl/syncser_rx.sv
module syncser_rx
    import syncser_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdi,
    input  logic              rx_ready,
    output logic              cts,
    output logic              rx_busy,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_err
);
    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    rx_state_t         state, state_nxt;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic              err_q;

    always_comb begin
        state_nxt = state;
        unique case (state)
            RX_IDLE:  if (!sdi)        state_nxt = RX_DATA;
            RX_DATA:  if (cnt == LAST) state_nxt = RX_ROUTE;
            RX_ROUTE:                  state_nxt = RX_HOLD;
            RX_HOLD:  if (rx_ready)    state_nxt = RX_IDLE;
            default:                   state_nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            cnt   <= '0;
            shreg <= '0;
            err_q <= 1'b0;
        end else begin
            state <= state_nxt;
            unique case (state)
                RX_IDLE: cnt <= '0;
                RX_DATA: begin
                    shreg <= {sdi, shreg[DATA_W-1:1]};
                    cnt   <= cnt + 1'b1;
                end
                RX_ROUTE: err_q <= sdi;
                RX_HOLD: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        cts      = (state == RX_IDLE);
        rx_valid = (state == RX_HOLD);
        rx_busy  = (state == RX_DATA) || (state == RX_ROUTE) ||
                   ((state == RX_IDLE) && !sdi);
        rx_data  = shreg;
        rx_err   = err_q;
    end
endmodule

// File: rtl/syncser_tx.sv
module syncser_tx
    import syncser_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    input  logic              rx_busy,
    output logic              tx_ready,
    output logic              sdo
);
    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    tx_state_t         state, state_nxt;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shreg;
    logic              line_nxt;

    always_comb begin
        tx_ready  = (state == TX_IDLE) && !rx_busy;
        state_nxt = state;
        unique case (state)
            TX_IDLE:  if (tx_valid && tx_ready) state_nxt = TX_START;
            TX_START:                           state_nxt = TX_DATA;
            TX_DATA:  if (cnt == LAST)          state_nxt = TX_ROUTE;
            TX_ROUTE:                           state_nxt = TX_IDLE;
            default:                            state_nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            cnt   <= '0;
            shreg <= '0;
        end else begin
            state <= state_nxt;
            unique case (state)
                TX_IDLE:  if (tx_valid && tx_ready) shreg <= tx_data;
                TX_START: cnt <= '0;
                TX_DATA: begin
                    shreg <= shreg >> 1;
                    cnt   <= cnt + 1'b1;
                end
                TX_ROUTE: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            TX_IDLE:  line_nxt = 1'b1;
            TX_START: line_nxt = 1'b0;
            TX_DATA:  line_nxt = shreg[0];
            TX_ROUTE: line_nxt = 1'b0;
            default:  line_nxt = 1'b1;
        endcase
    end

    // Launch on the falling edge so the partner samples a settled level.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) sdo <= 1'b1;
        else        sdo <= line_nxt;
    end
endmodule

// File: rtl/syncser_port.sv
module syncser_port #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              sclk,
    input  logic              rst_n,
    input  logic              sdi,
    output logic              sdo,
    output logic              cts,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic              rx_err
);
    logic rx_busy;

    syncser_rx #(.DATA_W(DATA_W)) rx_i (
        .clk      (sclk),
        .rst_n    (rst_n),
        .sdi      (sdi),
        .rx_ready (rx_ready),
        .cts      (cts),
        .rx_busy  (rx_busy),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_err   (rx_err)
    );

    syncser_tx #(.DATA_W(DATA_W)) tx_i (
        .clk      (sclk),
        .rst_n    (rst_n),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .rx_busy  (rx_busy),
        .tx_ready (tx_ready),
        .sdo      (sdo)
    );
endmodule

// File: rtl/syncser_chk.sv
module syncser_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              sclk,
    input logic              rst_n,
    input logic              sdi,
    input logic              cts,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              rx_ready
);
    // R6
    cts_drop_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (cts && !sdi) |=> !cts);

    // R7
    cts_hold_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (!cts && !(rx_valid && rx_ready)) |=> !cts);

    // R7
    rx_stable_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    // R5
    no_tx_in_rx_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (!cts && !rx_valid) |-> !tx_ready);

    // R4
    tx_once_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);
endmodule

bind syncser_port syncser_chk #(.DATA_W(DATA_W)) chk_i (
    .sclk     (sclk),
    .rst_n    (rst_n),
    .sdi      (sdi),
    .cts      (cts),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready)
);

// File: tb/syncser_port_tb_top.sv
`timescale 1ns/1ps
module syncser_port_tb_top;
    logic       sclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sdi = 1'b1;
    logic       sdo;
    logic       cts;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_ready = 1'b0;
    logic       rx_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 sclk = ~sclk;

    syncser_port #(.DATA_W(8)) dut_i (
        .sclk(sclk), .rst_n(rst_n), .sdi(sdi), .sdo(sdo), .cts(cts),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_err(rx_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Capture the ten partner samples after an acceptance edge; check the frame.
    task automatic capture_tx(input logic [7:0] b);
        logic [9:0] bits;
        for (int i = 0; i < 10; i++) begin
            @(posedge sclk); #1;
            bits[i] = sdo;
        end
        chk("R1 start bit", 32'(bits[0]), 32'd0);
        chk("R1 data bits", 32'(bits[8:1]), 32'(b));
        chk("R1 routing bit", 32'(bits[9]), 32'd0);
        @(posedge sclk); #1;
        chk("R2 idle after frame", 32'(sdo), 32'd1);
    endtask

    task automatic shift_rx(input logic [7:0] b, input logic route, input bit watch_tx);
        for (int i = 0; i < 8; i++) begin
            sdi = b[i];
            @(negedge sclk); #1;
            if (watch_tx) begin
                chk("R5 tx_ready low in rx", 32'(tx_ready), 32'd0);
                chk("R5 sdo high in rx", 32'(sdo), 32'd1);
            end
        end
        sdi = route;
        @(negedge sclk);
        sdi = 1'b1;
        #1;
    endtask

    task automatic release_rx(input logic [7:0] b);
        for (int i = 0; i < 3; i++) begin
            sdi = 1'b0;
            @(negedge sclk); #1;
            chk("R7 cts held low", 32'(cts), 32'd0);
            chk("R7 data held", 32'(rx_data), 32'(b));
        end
        sdi = 1'b1;
        rx_ready = 1'b1;
        @(negedge sclk);
        rx_ready = 1'b0;
        #1;
        chk("R7 cts back high", 32'(cts), 32'd1);
        chk("R7 rx_valid cleared", 32'(rx_valid), 32'd0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge sclk);
        rst_n = 1'b1;
        @(negedge sclk); #1;
        chk("R10 cts", 32'(cts), 32'd1);
        chk("R10 sdo", 32'(sdo), 32'd1);
        chk("R10 rx_valid", 32'(rx_valid), 32'd0);
        chk("R10 tx_ready", 32'(tx_ready), 32'd1);
    endtask

    task automatic test_rx(input logic [7:0] b, input logic route);
        @(negedge sclk); #1;
        chk("R6 cts high before start", 32'(cts), 32'd1);
        sdi = 1'b0;
        @(negedge sclk); #1;
        chk("R6 cts low after start", 32'(cts), 32'd0);
        shift_rx(b, route, 1'b0);
        chk("R3 rx_valid", 32'(rx_valid), 32'd1);
        chk("R3 rx_data", 32'(rx_data), 32'(b));
        chk("R9 rx_err", 32'(rx_err), 32'(route));
        release_rx(b);
    endtask

    task automatic test_tx(input logic [7:0] b);
        @(negedge sclk); #1;
        chk("R4 tx_ready idle", 32'(tx_ready), 32'd1);
        tx_data = b;
        tx_valid = 1'b1;
        @(posedge sclk); #1;
        chk("R2 high at accept", 32'(sdo), 32'd1);
        @(negedge sclk);
        tx_valid = 1'b0;
        #1;
        chk("R4 tx_ready busy", 32'(tx_ready), 32'd0);
        capture_tx(b);
    endtask

    task automatic test_priority(input logic [7:0] rb, input logic [7:0] tb);
        @(negedge sclk);
        sdi = 1'b0;
        tx_data = tb;
        tx_valid = 1'b1;
        #1;
        chk("R8 tx_ready low on same edge", 32'(tx_ready), 32'd0);
        @(negedge sclk); #1;
        chk("R8 cts low", 32'(cts), 32'd0);
        shift_rx(rb, 1'b0, 1'b1);
        chk("R8 rx byte", 32'(rx_data), 32'(rb));
        chk("R8 tx_ready after route", 32'(tx_ready), 32'd1);
        @(posedge sclk); #1;
        @(negedge sclk);
        tx_valid = 1'b0;
        capture_tx(tb);
        release_rx(rb);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_rx(8'hA5, 1'b0);
        test_rx(8'h01, 1'b0);
        test_rx(8'h3C, 1'b1);
        test_tx(8'h96);
        test_tx(8'h80);
        test_priority(8'h5A, 8'hC3);
        test_rx(8'hFF, 1'b0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule